// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

A single-port synchronous static RAM whose words are 32 bits wide and split into four 8-bit byte lanes. Every control, address and data input is sampled on the rising edge of one clock. Read data is not re-registered: once an edge has set up the word address, the stored word appears on the shared data bus later in that same cycle.

A base address is loaded with an address strobe. A 2-bit beat counter then moves the two low address bits across four beats. A static mode input selects the beat order: linear (wrapping add) or interleaved (XOR). Writes can cover all four lanes through a global enable, or chosen lanes through a byte-write master enable and per-lane enables. Three chip enables, sampled with the strobe, allow depth expansion. An asynchronous output enable controls the tri-state bus driver. A sleep input freezes the whole internal state.

A write commits at the edge that samples it. It goes to the address that this same edge establishes, so a read in the following cycle returns the new data.

Top module: `sync_burst_sram`

## Requirements
- R1: After the active-low reset `rst_n` is released, `dq_drive` stays 0 until an address strobe selects the device.
- R2: An edge with `addr_ld`=1 selects the device only if `ce_hi`=1, `ce_a_n`=0 and `ce_b_n`=0. A strobe with any other enable combination deselects the device. While deselected, the bus is not driven and writes leave memory unchanged.
- R3: Flow-through read: after the single edge that loads address A with the device selected and `oe_n`=0, `dq` carries the stored word at A, and `dq_drive`=1, in that same cycle.
- R4: With `burst_ilv`=0, beat k (0..3) after a load of base B addresses {B[5:2], (B[1:0]+k) mod 4}.
- R5: With `burst_ilv`=1, beat k after a load of base B addresses {B[5:2], B[1:0] XOR k}.
- R6: An edge with `addr_ld`=0 and `adv_n`=0 advances the beat count by one, wrapping after four beats. An edge with `adv_n`=1 keeps the current address.
- R7: `gw_n`=0 writes all four lanes of `dq`, whatever the values of `bwe_n` and `bw_n`.
- R8: With `gw_n`=1 and `bwe_n`=0, lane i (`dq` bits 8i+7..8i) is written exactly when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1, nothing is written.
- R9: `oe_n`=1 turns the bus driver off at once, with no clock edge. `oe_n`=0 turns it back on for a selected, awake device.
- R10: While `sleep`=1, writes are ignored, the address and beat count hold, and `dq_drive`=0. When `sleep` returns to 0, operation resumes from the held address.
- R11: An edge with both `addr_ld`=1 and `adv_n`=0 loads `addr` and ignores the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Word address loaded by the strobe |
| addr_ld | input | 1 | Address strobe: load base, clear beat count, sample chip enables |
| adv_n | input | 1 | Active-low burst advance |
| ce_hi | input | 1 | Active-high chip enable |
| ce_a_n | input | 1 | First active-low chip enable |
| ce_b_n | input | 1 | Second active-low chip enable |
| gw_n | input | 1 | Active-low global write, all lanes |
| bwe_n | input | 1 | Active-low byte-write master enable |
| bw_n | input | 4 | Active-low per-lane write enables |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Power-down: freezes all state |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | 32 | Shared data bus |
| dq_drive | output | 1 | High while the block drives `dq` |

## Verification
The assertions assume that `burst_ilv` is static during a burst and that `sleep` and the strobe are valid at every edge after reset. The bench changes `burst_ilv` only in the same cycle as a new strobe. It drives every control one time unit after the rising edge, so each edge samples settled values. The bench drives `dq` only while `oe_n` is high, so the bus never has two drivers.

// File: rtl/sbs_pkg.sv
// Package: shared types and the burst address helper for the burst SRAM.
// Assumes the beat counter is exactly two bits wide.
package sbs_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        BURST_LINEAR = 1'b0,
        BURST_XOR    = 1'b1
    } burst_mode_e;

    // Low address bits for a given start and beat number.
    function automatic logic [BEAT_W-1:0] beat_low(
        input burst_mode_e            mode,
        input logic [BEAT_W-1:0]      start,
        input logic [BEAT_W-1:0]      beat
    );
        logic [BEAT_W-1:0] res;
        if (mode == BURST_XOR) begin
            res = start ^ beat;
        end else begin
            res = start + beat;
        end
        return res;
    endfunction

endpackage

// File: rtl/sbs_select.sv
// Module: chip-select register and write-lane qualification.
// The select state is resampled only at a strobe edge and frozen during sleep.
// The lane enables refer to the write that commits at the current edge.
module sbs_select #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_ld,
    input  logic             sleep,
    input  logic             ce_hi,
    input  logic             ce_a_n,
    input  logic             ce_b_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic             sel_q,
    output logic [LANES-1:0] lane_we
);

    logic ce_all;
    logic sel_nxt;
    logic [LANES-1:0] lane_mask;

    // Purpose: combine the three chip enables into one select term.
    always_comb begin
        ce_all = ce_hi & ~ce_a_n & ~ce_b_n;
    end

    // Purpose: next select state; a strobe resamples it, sleep freezes it.
    always_comb begin
        if (sleep) begin
            sel_nxt = sel_q;
        end else if (addr_ld) begin
            sel_nxt = ce_all;
        end else begin
            sel_nxt = sel_q;
        end
    end

    // Purpose: merge the global write with the per-lane byte writes.
    always_comb begin
        if (!gw_n) begin
            lane_mask = '1;
        end else if (!bwe_n) begin
            lane_mask = ~bw_n;
        end else begin
            lane_mask = '0;
        end
    end

    // Purpose: gate the lane enables with selection and sleep.
    always_comb begin
        lane_we = (sel_nxt && !sleep) ? lane_mask : '0;
    end

    // Purpose: hold the select state between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel_nxt;
        end
    end

endmodule

// File: rtl/sbs_burst.sv
// Module: base address register and 2-bit beat counter.
// Produces the address that is current now and the address the next edge will set up.
// Assumes ADDR_W is at least the beat width.
module sbs_burst
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              addr_ld,
    input  logic              adv_n,
    input  burst_mode_e       mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [BEAT_W-1:0] beat_q
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] base_nxt;
    logic [BEAT_W-1:0] beat_nxt;

    // Purpose: choose the next base and beat; strobe beats advance, sleep holds.
    always_comb begin
        base_nxt = base_q;
        beat_nxt = beat_q;
        if (!sleep) begin
            if (addr_ld) begin
                base_nxt = addr;
                beat_nxt = '0;
            end else if (!adv_n) begin
                beat_nxt = beat_q + 1'b1;
            end
        end
    end

    // Purpose: form the current and next word addresses from base and beat.
    always_comb begin
        cur_addr = {base_q[ADDR_W-1 -: HI_W],
                    beat_low(mode, base_q[BEAT_W-1:0], beat_q)};
        nxt_addr = {base_nxt[ADDR_W-1 -: HI_W],
                    beat_low(mode, base_nxt[BEAT_W-1:0], beat_nxt)};
    end

    // Purpose: register the base address and beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            base_q <= base_nxt;
            beat_q <= beat_nxt;
        end
    end

endmodule

// File: rtl/sbs_array.sv
// Module: byte-lane storage array with an unregistered read port.
// Each lane has its own write enable. Contents are not reset.
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        // Purpose: commit this lane's byte when its enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Purpose: flow-through read of this lane.
        always_comb begin
            rdata[g*LANE_W +: LANE_W] = store[raddr];
        end
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Module: top of the synchronous flow-through burst SRAM.
// Connects the select logic, the burst address unit and the storage array,
// and drives the shared bus through an asynchronous output enable.
// Assumes the burst mode is static during a burst.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    addr_ld,
    input  logic                    adv_n,
    input  logic                    ce_hi,
    input  logic                    ce_a_n,
    input  logic                    ce_b_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    input  logic                    oe_n,
    inout  wire  [LANES*LANE_W-1:0] dq,
    output logic                    dq_drive
);

    localparam int DATA_W = LANES * LANE_W;

    logic              sel_q;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [BEAT_W-1:0] beat_q;
    logic [DATA_W-1:0] rdata;
    burst_mode_e       mode;

    // Purpose: map the mode pin to the burst order type.
    always_comb begin
        mode = burst_ilv ? BURST_XOR : BURST_LINEAR;
    end

    sbs_select #(.LANES(LANES)) sel_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_ld (addr_ld),
        .sleep   (sleep),
        .ce_hi   (ce_hi),
        .ce_a_n  (ce_a_n),
        .ce_b_n  (ce_b_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .sel_q   (sel_q),
        .lane_we (lane_we)
    );

    sbs_burst #(.ADDR_W(ADDR_W)) burst_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .addr_ld  (addr_ld),
        .adv_n    (adv_n),
        .mode     (mode),
        .addr     (addr),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr),
        .beat_q   (beat_q)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk     (clk),
        .waddr   (nxt_addr),
        .lane_we (lane_we),
        .wdata   (dq),
        .raddr   (cur_addr),
        .rdata   (rdata)
    );

    // Purpose: asynchronous drive decision for the shared bus.
    always_comb begin
        dq_drive = sel_q & ~sleep & ~oe_n;
    end

    assign dq = dq_drive ? rdata : {DATA_W{1'bz}};

endmodule

// File: rtl/sbs_checker.sv
// Module: property checker for the burst SRAM, bound to the top module.
// Watches the ports together with the internal address and beat registers.
module sbs_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_ld,
    input logic              adv_n,
    input logic              sleep,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_drive,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [1:0]        beat_q
);

    // R9: a disabled output enable never coexists with drive
    a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive);

    // R10: no drive while asleep
    a_r10_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_drive);

    // R10: state frozen across a sleeping edge
    a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(cur_addr) && $stable(beat_q)));

    // R11: strobe loads the presented address even with advance asserted
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ld && !sleep) |=> (cur_addr == $past(addr) && beat_q == 2'd0));

    // R6: advance steps the beat count by one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !addr_ld && !adv_n) |=> (beat_q == $past(beat_q) + 2'd1));

    // R6: no advance keeps the address
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !addr_ld && adv_n) |=> $stable(cur_addr));

endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_ld  (addr_ld),
    .adv_n    (adv_n),
    .sleep    (sleep),
    .oe_n     (oe_n),
    .addr     (addr),
    .dq_drive (dq_drive),
    .cur_addr (cur_addr),
    .beat_q   (beat_q)
);

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NV = 10;
    // {ilv, upper[3:0], start[1:0], beats[1:0]}
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 4'h0, 2'd0, 2'd3},
        {1'b0, 4'h3, 2'd2, 2'd1},
        {1'b0, 4'h5, 2'd3, 2'd2},
        {1'b0, 4'hA, 2'd1, 2'd3},
        {1'b0, 4'hF, 2'd2, 2'd3},
        {1'b1, 4'h1, 2'd1, 2'd1},
        {1'b1, 4'h7, 2'd2, 2'd3},
        {1'b1, 4'h9, 2'd3, 2'd2},
        {1'b1, 4'hC, 2'd1, 2'd3},
        {1'b1, 4'hE, 2'd0, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          addr_ld, adv_n, ce_hi, ce_a_n, ce_b_n;
    logic          gw_n, bwe_n, burst_ilv, sleep, oe_n;
    logic [3:0]    bw_n;
    logic [31:0]   tb_dq;
    logic          tb_drv;
    wire  [31:0]   dq_w;
    logic          dq_drive;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [64];

    assign dq_w = tb_drv ? tb_dq : 32'bz;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .addr_ld(addr_ld), .adv_n(adv_n),
        .ce_hi(ce_hi), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .burst_ilv(burst_ilv), .sleep(sleep),
        .oe_n(oe_n), .dq(dq_w), .dq_drive(dq_drive)
    );

    function automatic logic [31:0] pat(input int a);
        return {8'(a), 8'(a + 64), 8'(a + 128), ~8'(a)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        addr_ld = 0; adv_n = 1; ce_hi = 1; ce_a_n = 0; ce_b_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; sleep = 0; oe_n = 1; tb_drv = 0;
    endtask

    task automatic gwrite(input int a, input logic [31:0] d);
        idle(); addr = AW'(a); addr_ld = 1; gw_n = 0; tb_drv = 1; tb_dq = d;
        tick(); idle();
    endtask

    task automatic rd(input int a);
        idle(); addr = AW'(a); addr_ld = 1; oe_n = 0;
        tick(); addr_ld = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(); addr = '0; burst_ilv = 0; tb_dq = '0; rst_n = 0;
        tick(); tick(); rst_n = 1; oe_n = 0;
        tick();
        check("R1 reset drive off", 32'(dq_drive), 32'd0);

        for (int a = 0; a < 64; a++) begin
            model[a] = pat(a);
            gwrite(a, pat(a));
        end

        rd(9);
        check("R3 flow-through data", dq_w, model[9]);
        check("R3 drive on", 32'(dq_drive), 32'd1);

        // Table walk: R4 linear, R5 interleaved
        for (int v = 0; v < NV; v++) begin
            logic [1:0] s, k, lo;
            logic       ilv;
            int         ea;
            ilv = VEC[v][8]; s = VEC[v][3:2]; k = VEC[v][1:0];
            idle(); burst_ilv = ilv; addr = {VEC[v][7:4], s}; addr_ld = 1; oe_n = 0;
            tick();
            addr_ld = 0;
            for (int j = 0; j < int'(k); j++) begin
                adv_n = 0; tick();
            end
            adv_n = 1;
            lo = ilv ? (s ^ k) : (s + k);
            ea = int'({VEC[v][7:4], lo});
            check(ilv ? "R5 interleaved beat" : "R4 linear beat", dq_w, model[ea]);
        end
        burst_ilv = 0;

        // R6 wrap after four beats and hold with adv_n high
        rd(22);
        for (int j = 0; j < 4; j++) begin
            adv_n = 0; tick();
        end
        adv_n = 1;
        check("R6 wrap to start", dq_w, model[22]);
        tick(); tick();
        check("R6 hold without advance", dq_w, model[22]);

        // R11 strobe priority over advance
        idle(); oe_n = 0; addr = 6'd41; addr_ld = 1; adv_n = 0;
        tick(); idle(); oe_n = 0;
        check("R11 strobe wins", dq_w, model[41]);

        // R9 asynchronous output enable
        oe_n = 1; #1;
        check("R9 oe off async", 32'(dq_drive), 32'd0);
        oe_n = 0; #1;
        check("R9 oe on async", 32'(dq_drive), 32'd1);

        // R8 byte writes
        idle(); addr = 6'd5; addr_ld = 1; bwe_n = 0; bw_n = 4'b1010;
        tb_drv = 1; tb_dq = 32'h11223344; tick(); idle();
        model[5] = {model[5][31:24], 8'h22, model[5][15:8], 8'h44};
        rd(5);
        check("R8 selected lanes only", dq_w, model[5]);
        idle(); addr = 6'd5; addr_ld = 1; bw_n = 4'b0000; bwe_n = 1;
        tb_drv = 1; tb_dq = 32'hFFFFFFFF; tick(); idle();
        rd(5);
        check("R8 master off no write", dq_w, model[5]);

        // R7 global write overrides lane enables
        idle(); addr = 6'd6; addr_ld = 1; gw_n = 0; bwe_n = 0; bw_n = 4'hF;
        tb_drv = 1; tb_dq = 32'hCAFEF00D; tick(); idle();
        model[6] = 32'hCAFEF00D;
        rd(6);
        check("R7 global write", dq_w, model[6]);

        // R2 deselect: no drive, write ignored
        idle(); addr = 6'd7; addr_ld = 1; ce_b_n = 1; gw_n = 0;
        tb_drv = 1; tb_dq = 32'h0BADBEEF; tick(); idle();
        idle(); addr = 6'd7; addr_ld = 1; ce_hi = 0; oe_n = 0; tick(); addr_ld = 0;
        check("R2 deselected no drive", 32'(dq_drive), 32'd0);
        rd(7);
        check("R2 deselected write ignored", dq_w, model[7]);

        // R10 sleep
        rd(12); adv_n = 0; tick(); adv_n = 1;
        sleep = 1; adv_n = 0; addr_ld = 1; addr = 6'd50; gw_n = 0; oe_n = 1;
        tb_drv = 1; tb_dq = 32'h12345678; tick(); tick();
        check("R10 drive off asleep", 32'(dq_drive), 32'd0);
        idle(); oe_n = 0; #1;
        check("R10 address held", dq_w, model[13]);
        rd(50);
        check("R10 write ignored", dq_w, model[50]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule